// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block holds a small set of 32-bit window registers and decides, for each bus access, whether the access falls inside one of the transparently mapped windows. A window is described by an 8-bit base and an 8-bit don't-care mask, both compared against the top byte of the access address. It also carries an enable bit, a privilege filter, a cache-mode field and a write-protect bit. A matching access keeps its logical address as its physical address, so the block produces no address. It reports only that a window hit, which cache mode applies, and whether a write must be refused.

The number of windows is a parameter. When several windows claim the same access, the lowest-numbered window supplies the attributes. An instruction-side and a data-side copy of this block together form the usual pair of translation window sets.

Registers are loaded through a simple write port: a strobe, a window index and a data word. Any register can be read back combinationally through a separate index. Matching is purely combinational from the stored registers and the access inputs, so a new register value affects accesses from the cycle after its write.

Top module: `ttr_match_unit`

## Requirements
- R1: After reset every window register reads 0 and no access hits.
- R2: A write with `wr_en`=1 loads `wr_data` into window `wr_sel` at the clock edge. `rd_data` shows window `rd_sel` in the following cycle, and the other windows are unchanged.
- R3: Reserved bits (12:10, 7, 4:3, 1:0) always read back 0, so a write of 0xFFFFFFFF reads back 0xFFFFE364.
- R4: The base field (bits 31:24) is compared with `addr[31:24]`. A 1 in mask bit 16+k (field bits 23:16) makes base bit 24+k a don't-care.
- R5: A window whose enable bit (bit 15) is 0 never hits.
- R6: Privilege field bits 14:13 decide which accesses can hit. The value 00 lets only user accesses (`is_super`=0) hit, 01 lets only supervisor accesses hit, and 1x lets either mode hit.
- R7: On a hit, `cache_mode` carries field bits 6:5 of the selected window (00 write-through, 01 copyback, 10 noncacheable serialized, 11 noncacheable). With no hit it is 00.
- R8: `wr_fault` is 1 only for a write access (`is_write`=1) that hits a window whose bit 2 is 1. Reads and writes to unprotected windows never fault.
- R9: User attribute bits 9:8 are stored and read back, but they have no effect on hit, cache mode or fault.
- R10: When several windows hit, the lowest-numbered one supplies `cache_mode` and the write-protect decision.
- R11: The value 0x807FC040 hits every address from 0x80000000 upward in both modes, noncacheable serialized and writable. The value 0x0000C000 hits 0x00000000 to 0x00FFFFFF in both modes, write-through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Window index for the write |
| wr_data | input | 32 | Register value to write |
| rd_sel | input | SEL_W | Window index for readback |
| rd_data | output | 32 | Stored value of window `rd_sel` |
| addr | input | ADDR_W | Logical address of the access |
| is_super | input | 1 | 1 = supervisor access, 0 = user access |
| is_write | input | 1 | 1 = write access, 0 = read access |
| hit | output | 1 | Access lies in an enabled window |
| cache_mode | output | 2 | Cache mode of the winning window |
| wr_fault | output | 1 | Write refused by a protected window |

## Verification
The assertions check the relations between outputs on every cycle. A fault never appears without a hit on a write, a miss always reports cache mode 00, and reserved bits never read back as 1. A readback taken after a write matches the written value with the reserved bits cleared. Window arithmetic cannot be shown by those properties and comes only from the bench's scenarios. That includes the base/mask comparison, the privilege filter, the enable gate, the two reference values and the priority between overlapping windows. The bench compares against its reference model every cycle.

// File: rtl/ttr_pkg.sv
// Shared types for the translation window matcher.
// Assumes a 32-bit window register whose top byte is compared with the
// top byte of the access address.
package ttr_pkg;

    localparam int TTR_W = 32;

    // Bits that are stored; every other bit is reserved and held at zero.
    localparam logic [TTR_W-1:0] TTR_KEEP = 32'hFFFF_E364;

    typedef struct packed {
        logic [7:0] base;
        logic [7:0] mask;
        logic       en;
        logic [1:0] priv;
        logic [2:0] rsv_a;
        logic [1:0] uattr;
        logic       rsv_b;
        logic [1:0] cmode;
        logic [1:0] rsv_c;
        logic       wp;
        logic [1:0] rsv_d;
    } ttr_t;

    typedef enum logic [1:0] {
        CM_WRTHRU = 2'b00,
        CM_COPYBK = 2'b01,
        CM_NC_SER = 2'b10,
        CM_NC     = 2'b11
    } cmode_e;

endpackage

// File: rtl/ttr_slot.sv
// One translation window: stores its register (reserved bits forced to
// zero) and compares the access tag and privilege against it.
// Assumes the caller has already decoded the write strobe for this slot.
module ttr_slot
    import ttr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TTR_W-1:0] load_val,
    input  logic [7:0]       tag,
    input  logic             is_super,
    output logic             hit,
    output logic [1:0]       cmode,
    output logic             wp,
    output logic [TTR_W-1:0] value
);

    ttr_t reg_q;
    logic tag_ok;
    logic priv_ok;

    // Register storage with reserved bits cleared on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (load)
            reg_q <= ttr_t'(load_val & TTR_KEEP);
    end

    // Tag and privilege comparison for this window.
    always_comb begin
        tag_ok  = (((tag ^ reg_q.base) & ~reg_q.mask) == 8'h00);
        priv_ok = reg_q.priv[1] | (reg_q.priv[0] == is_super);
        hit     = reg_q.en & tag_ok & priv_ok;
    end

    assign cmode = reg_q.cmode;
    assign wp    = reg_q.wp;
    assign value = reg_q;

endmodule

// File: rtl/ttr_prio.sv
// Fixed-priority combiner: the lowest-numbered hitting window supplies
// the cache mode and write-protect bit.
// Assumes at least one window.
module ttr_prio #(
    parameter int NUM = 2
) (
    input  logic [NUM-1:0]      hit_vec,
    input  logic [NUM-1:0][1:0] cm_vec,
    input  logic [NUM-1:0]      wp_vec,
    output logic                any_hit,
    output logic [1:0]          cm_sel,
    output logic                wp_sel
);

    // Scan from the highest index down so the lowest hitting one wins.
    always_comb begin
        any_hit = 1'b0;
        cm_sel  = 2'b00;
        wp_sel  = 1'b0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                cm_sel  = cm_vec[i];
                wp_sel  = wp_vec[i];
            end
        end
    end

endmodule

// File: rtl/ttr_match_unit.sv
// Top of the translation window matcher: NUM_WIN window slots, a write
// decoder, a readback multiplexer and the priority combiner.
// Assumes addresses of at least 8 bits; matching uses the top byte only.
module ttr_match_unit
    import ttr_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [TTR_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [TTR_W-1:0]  rd_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_super,
    input  logic              is_write,
    output logic              hit,
    output logic [1:0]        cache_mode,
    output logic              wr_fault
);

    localparam int TAG_LSB = ADDR_W - 8;

    logic [7:0]                  tag;
    logic [NUM_WIN-1:0]          hit_vec;
    logic [NUM_WIN-1:0][1:0]     cm_vec;
    logic [NUM_WIN-1:0]          wp_vec;
    logic [NUM_WIN-1:0][TTR_W-1:0] val_vec;
    logic                        wp_win;
    logic                        unused_low;

    assign tag        = addr[ADDR_W-1:TAG_LSB];
    assign unused_low = ^addr[TAG_LSB-1:0];

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            ttr_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (wr_en && (int'(wr_sel) == g)),
                .load_val (wr_data),
                .tag      (tag),
                .is_super (is_super),
                .hit      (hit_vec[g]),
                .cmode    (cm_vec[g]),
                .wp       (wp_vec[g]),
                .value    (val_vec[g])
            );
        end
    endgenerate

    ttr_prio #(.NUM(NUM_WIN)) u_prio (
        .hit_vec (hit_vec),
        .cm_vec  (cm_vec),
        .wp_vec  (wp_vec),
        .any_hit (hit),
        .cm_sel  (cache_mode),
        .wp_sel  (wp_win)
    );

    // Write refusal for protected windows.
    assign wr_fault = hit & wp_win & is_write;

    // Readback multiplexer; out-of-range indices read zero.
    always_comb begin
        rd_data = '0;
        if (int'(rd_sel) < NUM_WIN)
            rd_data = val_vec[rd_sel];
    end

endmodule

// File: rtl/ttr_match_chk.sv
// Property checker for ttr_match_unit, attached by bind below.
// Assumes the port names of the top module.
module ttr_match_chk #(
    parameter int SEL_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [31:0]      wr_data,
    input logic [SEL_W-1:0] rd_sel,
    input logic [31:0]      rd_data,
    input logic             is_write,
    input logic             hit,
    input logic [1:0]       cache_mode,
    input logic             wr_fault
);

    // R8
    fault_needs_write_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fault |-> (hit && is_write));

    // R7
    miss_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (cache_mode == 2'b00));

    // R3
    reserved_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 32'h0000_1C9B) == 32'h0);

    // R2
    readback_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_sel) == rd_sel) && !wr_en)
        |-> (rd_data == ($past(wr_data) & 32'hFFFF_E364)));

endmodule

bind ttr_match_unit ttr_match_chk #(.SEL_W(SEL_W)) u_ttr_match_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .is_write   (is_write),
    .hit        (hit),
    .cache_mode (cache_mode),
    .wr_fault   (wr_fault)
);

// File: tb/ttr_match_unit_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle, plus directed
// scenarios for each requirement.
module ttr_match_unit_bench;

    localparam int NW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [0:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [31:0] addr = '0;
    logic        is_super = 1'b0;
    logic        is_write = 1'b0;
    logic        hit;
    logic [1:0]  cache_mode;
    logic        wr_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mdl [NW];

    always #2.5 clk = ~clk;

    ttr_match_unit u_ttr_match_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .addr(addr), .is_super(is_super), .is_write(is_write),
        .hit(hit), .cache_mode(cache_mode), .wr_fault(wr_fault)
    );

    // Reference register file.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mdl[i] <= 32'h0;
        end else if (wr_en) begin
            mdl[wr_sel] <= wr_data & 32'hFFFF_E364;
        end
    end

    function automatic bit win_hits(input logic [31:0] r, input logic [31:0] a, input logic s);
        bit ok;
        ok = r[15];
        for (int k = 0; k < 8; k++)
            if (!r[16+k] && (r[24+k] != a[24+k])) ok = 0;
        if (r[14:13] == 2'b00 && s) ok = 0;
        if (r[14:13] == 2'b01 && !s) ok = 0;
        return ok;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit eh; logic [1:0] ec; bit ef;
            eh = 0; ec = 2'b00; ef = 0;
            for (int i = NW - 1; i >= 0; i--) begin
                if (win_hits(mdl[i], addr, is_super)) begin
                    eh = 1; ec = mdl[i][6:5]; ef = mdl[i][2] & is_write;
                end
            end
            chk("R4 model hit", {31'h0, hit}, {31'h0, eh});
            chk("R7 model cache_mode", {30'h0, cache_mode}, {30'h0, ec});
            chk("R8 model wr_fault", {31'h0, wr_fault}, {31'h0, ef});
            chk("R2 model rd_data", rd_data, mdl[rd_sel]);
        end
    end

    task automatic wr(input int sel, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_sel = sel[0:0]; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic acc(input logic [31:0] a, input logic s, input logic w);
        addr = a; is_super = s; is_write = w;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic h, input logic [1:0] cm, input logic f);
        chk(req, {28'h0, h, cm, f}, {28'h0, h, cm, f} ^ {28'h0, hit ^ h, cache_mode ^ cm, wr_fault ^ f});
    endtask

    // Directed scenarios.
    initial begin
        repeat (3) @(posedge clk);
        #1;
        rd_sel = 0; acc(32'h9000_0000, 1, 0);
        chk("R1 reset rd0", rd_data, 32'h0);
        chk("R1 reset miss", {31'h0, hit}, 32'h0);
        rst_n = 1;
        @(posedge clk); #1;
        rd_sel = 1; acc(32'h0000_0000, 0, 0);
        chk("R1 reset rd1", rd_data, 32'h0);

        // R11 high window
        wr(0, 32'h807F_C040);
        acc(32'h9000_0000, 1, 1);
        chk("R11 high hit super", {29'h0, hit, cache_mode}, {29'h0, 1'b1, 2'b10});
        chk("R11 high writable", {31'h0, wr_fault}, 32'h0);
        acc(32'hFFFF_FFFC, 0, 0);
        chk("R11 high hit user", {31'h0, hit}, 32'h1);
        acc(32'h7FFF_FFFF, 1, 0);
        chk("R11 below window miss", {31'h0, hit}, 32'h0);

        // R2/R3 readback, other window untouched
        wr(0, 32'hFFFF_FFFF);
        rd_sel = 0; acc(32'h0, 0, 0);
        chk("R3 reserved cleared", rd_data, 32'hFFFF_E364);
        rd_sel = 1; #1;
        chk("R2 other window unchanged", rd_data, 32'h0);

        // R11 low window
        wr(0, 32'h0000_C000);
        acc(32'h00FF_FFFF, 0, 1);
        chk("R11 low hit wt", {29'h0, hit, cache_mode}, {29'h0, 1'b1, 2'b00});
        acc(32'h0100_0000, 1, 0);
        chk("R11 low upper miss", {31'h0, hit}, 32'h0);

        // R5 enable
        wr(0, 32'h00FF_4000);
        acc(32'h1234_5678, 1, 0);
        chk("R5 disabled miss", {31'h0, hit}, 32'h0);

        // R6 privilege
        wr(0, 32'h00FF_8000);
        acc(32'h4000_0000, 0, 0);
        chk("R6 user-only user", {31'h0, hit}, 32'h1);
        acc(32'h4000_0000, 1, 0);
        chk("R6 user-only super", {31'h0, hit}, 32'h0);
        wr(0, 32'h00FF_A000);
        acc(32'h4000_0000, 1, 0);
        chk("R6 super-only super", {31'h0, hit}, 32'h1);
        acc(32'h4000_0000, 0, 0);
        chk("R6 super-only user", {31'h0, hit}, 32'h0);

        // R4 base/mask
        wr(0, 32'h12F0_C060);
        acc(32'h5200_0000, 0, 0);
        chk("R4 masked nibble hit", {29'h0, hit, cache_mode}, {29'h0, 1'b1, 2'b11});
        acc(32'h5300_0000, 0, 0);
        chk("R4 unmasked bit miss", {29'h0, hit, cache_mode}, 32'h0);

        // R8 write protect
        wr(0, 32'h00FF_C004);
        acc(32'h2000_0000, 1, 1);
        chk("R8 protected write", {31'h0, wr_fault}, 32'h1);
        acc(32'h2000_0000, 1, 0);
        chk("R8 protected read", {31'h0, wr_fault}, 32'h0);
        wr(0, 32'h00FF_C000);
        acc(32'h2000_0000, 1, 1);
        chk("R8 unprotected write", {31'h0, wr_fault}, 32'h0);

        // R9 user attributes
        wr(0, 32'h00FF_8320);
        rd_sel = 0; acc(32'h3000_0000, 1, 0);
        chk("R9 attr super miss", {31'h0, hit}, 32'h0);
        chk("R9 attr readback", rd_data, 32'h00FF_8320);
        acc(32'h3000_0000, 0, 0);
        chk("R9 attr user hit", {29'h0, hit, cache_mode}, {29'h0, 1'b1, 2'b01});

        // R10 priority
        wr(0, 32'h00FF_C020);
        wr(1, 32'h00FF_C044);
        acc(32'h6000_0000, 0, 1);
        chk("R10 low index wins", {29'h0, hit, cache_mode}, {29'h0, 1'b1, 2'b01});
        chk("R10 low index no fault", {31'h0, wr_fault}, 32'h0);
        wr(0, 32'h0000_0000);
        acc(32'h6000_0000, 0, 1);
        chk("R10 second window", {29'h0, hit, cache_mode}, {29'h0, 1'b1, 2'b10});
        chk("R10 second window fault", {31'h0, wr_fault}, 32'h1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(5 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule